// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Request Fan-out

This block keeps the interrupt state of a UART register interface. An eleven-bit raw status word collects single-cycle event pulses from the receive, transmit, receive-timeout, modem-status and error logic. A mask word of the same width selects which raw bits may raise a request. Software reads the raw word, the mask and their AND through a simple register strobe. It clears raw bits by writing ones to a clear address, and the neighbouring logic can also clear them with its own pulses. A write to the data register always sets the transmit raw bit.

The masked word drives six request lines. Five of them carry one group each: receive, transmit, receive timeout, modem status and error. The sixth is the OR of all groups. All six are registers, and each is computed from the next-state status and mask words. They therefore change on the same clock edge as the status they reflect, and they never glitch.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the raw status word and the mask word, drives all six request lines low and clears the read data.
- R2: An event pulse on bit n of `evt_set` sets raw bit n at that clock edge. Bit map: 0 ring indicator, 1 clear-to-send, 2 carrier detect, 3 data-set-ready, 4 receive, 5 transmit, 6 receive timeout, 7 framing error, 8 parity error, 9 break, 10 overrun.
- R3: A write to address 2 loads the mask from `wdata[10:0]`. A read of address 2 returns the mask, zero-extended.
- R4: A read of address 1 returns the raw status word. A read of address 3 returns the raw word AND the mask.
- R5: A write to address 4 clears every raw bit whose `wdata` bit is 1 and leaves the other raw bits unchanged. A pulse on bit n of `evt_clr` also clears raw bit n.
- R6: A read of address 4, and a read of any unmapped address (5 to 7), returns zero. Read data is registered: it appears one cycle after `rd_en` and is zero in any cycle that follows no read.
- R7: Writes to addresses 1 and 3 change neither the raw word nor the mask.
- R8: Every write to address 0, the data register, sets raw bit 5 (transmit), whatever value is written.
- R9: When a set pulse and a clear (a clear write or a clear pulse) hit the same raw bit in one cycle, the bit ends up set.
- R10: `irq_rx`, `irq_tx` and `irq_rt` follow masked bits 4, 5 and 6. `irq_ms` is the OR of masked bits 3:0. `irq_err` is the OR of masked bits 10:7.
- R11: `irq_any` is high exactly when at least one masked bit of any group is set.
- R12: The request lines are registered. After a mask write, a clear write, a data write or an event pulse, they show the new state in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| evt_set | input | 11 | Per-bit raw status set pulses |
| evt_clr | input | 11 | Per-bit raw status clear pulses |
| irq_any | output | 1 | Combined request |
| irq_rx | output | 1 | Receive request |
| irq_tx | output | 1 | Transmit request |
| irq_rt | output | 1 | Receive-timeout request |
| irq_ms | output | 1 | Modem-status request |
| irq_err | output | 1 | Error request |

## Verification
A wrong raw or mask bit shows up one cycle after the edge that caused it: on a request line, if that bit is unmasked, and otherwise in the next read of address 1, 2 or 3. A grouping fault, such as a modem or error bit routed to the wrong line, appears when single bits are walked under an all-ones mask. A wrong set/clear priority, or a clear that reaches the wrong bits, appears in the raw read that directly follows the colliding cycle. Many pseudo-random pairs of raw and mask words then test the masked read and all six lines together against arithmetic expectations.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int IRQ_W   = 11;
  localparam int N_LINES = 5;

  // Raw status bit positions
  localparam int B_RI  = 0;
  localparam int B_CTS = 1;
  localparam int B_DCD = 2;
  localparam int B_DSR = 3;
  localparam int B_RX  = 4;
  localparam int B_TX  = 5;
  localparam int B_RT  = 6;
  localparam int B_FE  = 7;
  localparam int B_PE  = 8;
  localparam int B_BE  = 9;
  localparam int B_OE  = 10;

  // Register addresses
  localparam int A_DATA = 0;
  localparam int A_RAW  = 1;
  localparam int A_MASK = 2;
  localparam int A_MSKD = 3;
  localparam int A_CLR  = 4;

  // Group selection for each individual request line:
  // 0 receive, 1 transmit, 2 receive timeout, 3 modem status, 4 error
  function automatic logic [IRQ_W-1:0] grp_sel(input int g);
    logic [IRQ_W-1:0] m;
    m = '0;
    case (g)
      0:       m[B_RX] = 1'b1;
      1:       m[B_TX] = 1'b1;
      2:       m[B_RT] = 1'b1;
      3:       m[B_DSR:B_RI] = '1;
      default: m[B_OE:B_FE] = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IRQ_W-1:0]  evt_set,
  input  logic [IRQ_W-1:0]  evt_clr,
  output logic [IRQ_W-1:0]  raw_q,
  output logic [IRQ_W-1:0]  mask_q,
  output logic [IRQ_W-1:0]  raw_d,
  output logic [IRQ_W-1:0]  mask_d
);

  logic             wr_data, wr_mask, wr_clr;
  logic [IRQ_W-1:0] clr_vec, set_vec;

  assign wr_data = wr_en && (addr == ADDR_W'(A_DATA));
  assign wr_mask = wr_en && (addr == ADDR_W'(A_MASK));
  assign wr_clr  = wr_en && (addr == ADDR_W'(A_CLR));

  always_comb begin
    clr_vec = evt_clr;
    if (wr_clr) clr_vec = clr_vec | wdata[IRQ_W-1:0];
    set_vec = evt_set;
    if (wr_data) set_vec[B_TX] = 1'b1;
    // set has priority over clear
    raw_d  = (raw_q & ~clr_vec) | set_vec;
    mask_d = wr_mask ? wdata[IRQ_W-1:0] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (raw_q == '0 && mask_q == '0));
  // R3
  a_r3_mask_load: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> mask_q == $past(wdata[IRQ_W-1:0]));
  // R2 / R9: a set pulse always lands
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));
  // R5
  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && evt_set == '0) |=> ((raw_q & $past(wdata[IRQ_W-1:0])) == '0));
  // R8
  a_r8_tx_on_data: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> raw_q[B_TX]);
  // R7
  a_r7_ro_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(A_RAW) || addr == ADDR_W'(A_MSKD))
     && evt_set == '0 && evt_clr == '0) |=> ($stable(raw_q) && $stable(mask_q)));

endmodule

// File: rtl/uart_irq_fanout.sv
module uart_irq_fanout
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [IRQ_W-1:0]   raw_d,
  input  logic [IRQ_W-1:0]   mask_d,
  output logic [N_LINES-1:0] line_q,
  output logic               any_q
);

  logic [IRQ_W-1:0]   active;
  logic [N_LINES-1:0] line_d;

  assign active = raw_d & mask_d;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    localparam logic [IRQ_W-1:0] SEL = grp_sel(g);
    assign line_d[g] = |(active & SEL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      any_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      any_q  <= |line_d;
    end
  end

endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IRQ_W-1:0]  raw_q,
  input  logic [IRQ_W-1:0]  mask_q,
  output logic [DATA_W-1:0] rdata
);

  logic [IRQ_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(A_RAW))       sel = raw_q;
    else if (addr == ADDR_W'(A_MASK)) sel = mask_q;
    else if (addr == ADDR_W'(A_MSKD)) sel = raw_q & mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= DATA_W'(sel);
    else            rdata <= '0;
  end

  // R6
  a_r6_clr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(A_CLR)) |=> rdata == '0);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [IRQ_W-1:0]  evt_set,
  input  logic [IRQ_W-1:0]  evt_clr,
  output logic              irq_any,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rt,
  output logic              irq_ms,
  output logic              irq_err
);

  logic [IRQ_W-1:0]   raw_q, mask_q, raw_d, mask_d;
  logic [N_LINES-1:0] line_q;

  uart_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .evt_set(evt_set), .evt_clr(evt_clr),
    .raw_q(raw_q), .mask_q(mask_q), .raw_d(raw_d), .mask_d(mask_d)
  );

  uart_irq_fanout u_fan (
    .clk(clk), .rst(rst), .raw_d(raw_d), .mask_d(mask_d),
    .line_q(line_q), .any_q(irq_any)
  );

  uart_irq_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .raw_q(raw_q), .mask_q(mask_q), .rdata(rdata)
  );

  assign irq_rx  = line_q[0];
  assign irq_tx  = line_q[1];
  assign irq_rt  = line_q[2];
  assign irq_ms  = line_q[3];
  assign irq_err = line_q[4];

  // R10: lines agree with the stored status and mask registers
  a_r10_line_map: assert property (@(posedge clk) disable iff (rst)
    (irq_rx == (raw_q[B_RX] & mask_q[B_RX])) &&
    (irq_tx == (raw_q[B_TX] & mask_q[B_TX])) &&
    (irq_ms == |(raw_q[B_DSR:B_RI] & mask_q[B_DSR:B_RI])) &&
    (irq_err == |(raw_q[B_OE:B_FE] & mask_q[B_OE:B_FE])));
  // R11
  a_r11_combined: assert property (@(posedge clk) disable iff (rst)
    irq_any == |(raw_q & mask_q));

endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [10:0] evt_set = '0, evt_clr = '0;
  logic        irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_set(evt_set), .evt_clr(evt_clr),
    .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rt(irq_rt),
    .irq_ms(irq_ms), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] lines_of(input logic [10:0] r, input logic [10:0] m);
    logic [10:0] a;
    a = r & m;
    return {|a, a[4], a[5], a[6], |a[3:0], |a[10:7]};
  endfunction

  function automatic logic [5:0] lines_now();
    return {irq_any, irq_rx, irq_tx, irq_rt, irq_ms, irq_err};
  endfunction

  task automatic step();
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0; evt_set = '0; evt_clr = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; step();
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; step(); d = rdata;
  endtask

  task automatic pulse(input logic [10:0] s, input logic [10:0] c);
    @(negedge clk); evt_set = s; evt_clr = c; step();
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] lf;
    logic [10:0] r, m;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 lines", {10'd0, lines_now()}, 16'd0);
    chk("R1 rdata", rdata, 16'd0);
    rd(3'd1, d); chk("R1 raw", d, 16'd0);
    rd(3'd2, d); chk("R1 mask", d, 16'd0);

    // R2, R10, R11 walk each bit with all-ones mask
    wr(3'd2, 16'hFFFF);
    rd(3'd2, d); chk("R3 mask readback", d, 16'h07FF);
    for (int b = 0; b < 11; b++) begin
      wr(3'd4, 16'h07FF);
      pulse(11'(1 << b), '0);
      chk("R12 R10 R11 lines after pulse", {10'd0, lines_now()},
          {10'd0, lines_of(11'(1 << b), 11'h7FF)});
      rd(3'd1, d); chk("R2 raw bit", d, 16'(1 << b));
    end

    // R4 R10 R11 pseudo-random raw/mask pairs
    lf = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r = lf[10:0];
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      m = lf[15:5];
      wr(3'd4, 16'hFFFF);
      wr(3'd2, {5'd0, m});
      chk("R12 mask write lines", {10'd0, lines_now()}, 16'd0);
      pulse(r, '0);
      chk("R10 R11 lines", {10'd0, lines_now()}, {10'd0, lines_of(r, m)});
      rd(3'd3, d); chk("R4 masked", d, {5'd0, r & m});
      rd(3'd1, d); chk("R4 raw", d, {5'd0, r});
    end

    // R5 partial W1C
    wr(3'd2, 16'h07FF);
    pulse(11'h7FF, '0);
    wr(3'd4, 16'h0155);
    rd(3'd1, d); chk("R5 w1c", d, 16'h06AA);
    pulse('0, 11'h00A);
    rd(3'd1, d); chk("R5 clr pulse", d, 16'h06A0);
    chk("R10 ms low", {15'd0, irq_ms}, 16'd0);
    // R6
    rd(3'd4, d); chk("R6 clear reads 0", d, 16'd0);
    rd(3'd6, d); chk("R6 unmapped reads 0", d, 16'd0);
    @(negedge clk); chk("R6 idle rdata", rdata, 16'd0);
    // R7
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h07FF);
    rd(3'd1, d); chk("R7 raw unchanged", d, 16'h06A0);
    rd(3'd2, d); chk("R7 mask unchanged", d, 16'h07FF);
    // R8
    wr(3'd4, 16'hFFFF);
    wr(3'd2, 16'h0020);
    chk("R8 tx low before", {15'd0, irq_tx}, 16'd0);
    wr(3'd0, 16'h0000);
    chk("R8 R12 tx line", {15'd0, irq_tx}, 16'd1);
    chk("R11 any", {15'd0, irq_any}, 16'd1);
    rd(3'd1, d); chk("R8 tx raw", d, 16'h0020);
    // R9 set wins against clear write and clear pulse
    wr(3'd4, 16'hFFFF);
    @(negedge clk); wr_en = 1'b1; addr = 3'd4; wdata = 16'h07FF; evt_set = 11'h041; step();
    rd(3'd1, d); chk("R9 set over w1c", d, 16'h0041);
    pulse(11'h100, 11'h100);
    rd(3'd1, d); chk("R9 set over clr pulse", d, 16'h0141);
    // R1 reset mid-run
    @(negedge clk); rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
    rd(3'd1, d); chk("R1 raw after reset", d, 16'd0);
    rd(3'd2, d); chk("R1 mask after reset", d, 16'd0);
    chk("R1 lines after reset", {10'd0, lines_now()}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule